// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block turns a qualified edge on either of two trigger inputs into a single output pulse. The pulse width is a count of clock cycles, not an analog time constant. One trigger input is active-low and fires on its falling edge, but only while the other trigger is high. The other trigger input is active-high and fires on its rising edge, but only while the first trigger is low. A trigger that arrives while a pulse is running restarts the count. The pulse therefore always ends a full width after the latest trigger.

All three control inputs are asynchronous and are synchronized on entry. A low level on the clear input overrides everything else. It drops the pulse at the output at once and cancels the count. A build parameter selects whether the release of clear can itself start a pulse. The block drives a true output and a complementary output.

Top module: `oneshot_pulse`

## Requirements
- R1: A falling edge on `trig_n_i` starts a pulse when `trig_p_i` is high and `clear_ni` is high. A falling edge while `trig_p_i` is low starts nothing.
- R2: A rising edge on `trig_p_i` starts a pulse when `trig_n_i` is low and `clear_ni` is high. A rising edge while `trig_n_i` is high starts nothing.
- R3: When the inputs change between two rising clock edges, `pulse_o` rises after the third following rising edge. It then stays high for exactly `width_i` cycles. `width_i` is an unsigned count sampled when the trigger is accepted.
- R4: A qualified trigger during a pulse reloads the count from the current `width_i`. The pulse then ends exactly that many cycles after the new trigger takes effect, which may be earlier or later than the original end.
- R5: While `clear_ni` is low, `pulse_o` is low and `pulse_no` is high in the same instant, with no clock edge needed. A pulse cut short by clear does not resume after release.
- R6: Trigger edges that occur while `clear_ni` is low start no pulse, either then or after release.
- R7: With `RESET_TRIG`=1, a low-to-high transition of `clear_ni` starts a pulse when `trig_n_i` is low and `trig_p_i` is high, with the same latency as R3. With `RESET_TRIG`=0, the same transition starts nothing.
- R8: Static trigger levels start no pulse. Neither does a rising edge on `trig_n_i` or a falling edge on `trig_p_i`.
- R9: A trigger accepted with `width_i` equal to 0 produces no pulse.
- R10: `pulse_no` is always the inverse of `pulse_o`. While `rst_ni` is low, `pulse_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of all flops |
| trig_n_i | input | 1 | Active-low trigger, fires on falling edge |
| trig_p_i | input | 1 | Active-high trigger, fires on rising edge |
| clear_ni | input | 1 | Active-low overriding clear |
| width_i | input | WIDTH_W | Pulse width in clock cycles |
| pulse_o | output | 1 | True pulse output |
| pulse_no | output | 1 | Complementary pulse output |

## Verification
All state lives in the synchronizers, the previous-sample register and the down-counter. A corrupted count therefore shows at `pulse_o` as a pulse that ends a cycle early or late, either at the end of the first pulse or right after a retrigger. A wrong previous-sample value shows as a spurious or missing pulse. That effect appears at the third clock edge after the input change. The bench samples every cycle of each pulse window, so an off-by-one at either end of a pulse is caught in the cycle where it happens.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // packed order matches the {clear, p, n} concatenation used at the top
  typedef struct packed {
    logic clr_n;
    logic trig_p;
    logic trig_n;
  } trig_sample_t;

  localparam int unsigned SAMPLE_W = $bits(trig_sample_t);

  // idle levels: cleared, positive trigger low, negative trigger high
  localparam trig_sample_t SAMPLE_RST = '{clr_n: 1'b0, trig_p: 1'b0, trig_n: 1'b1};

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int unsigned        WIDTH  = 3,
  parameter int unsigned        STAGES = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/oneshot_trigger.sv
module oneshot_trigger
  import oneshot_pkg::*;
#(
  parameter bit RESET_TRIG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  trig_sample_t cur_i,
  output logic         fire_o,
  output logic         armed_o
);

  trig_sample_t prev_q;
  logic         fall_n, rise_p, rise_clr;
  logic         clr_fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= SAMPLE_RST;
    else         prev_q <= cur_i;
  end

  assign fall_n   =  prev_q.trig_n & ~cur_i.trig_n;
  assign rise_p   = ~prev_q.trig_p &  cur_i.trig_p;
  assign rise_clr = ~prev_q.clr_n  &  cur_i.clr_n;

  if (RESET_TRIG) begin : g_clr_trig
    assign clr_fire = rise_clr & ~cur_i.trig_n & cur_i.trig_p;
  end else begin : g_no_clr_trig
    assign clr_fire = 1'b0;
  end

  assign armed_o = cur_i.clr_n;
  assign fire_o  = cur_i.clr_n &
                   ((fall_n & cur_i.trig_p) | (rise_p & ~cur_i.trig_n) | clr_fire);

  // a fire always rests on a change of at least one sampled input
  AST_FIRE_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (cur_i != prev_q)) else $error("fire on static inputs"); // R8

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int unsigned WIDTH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               armed_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               busy_o
);

  logic [WIDTH_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!armed_i) begin
      cnt_q <= '0;
    end else if (fire_i) begin
      cnt_q <= width_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> !busy_o) else $error("count survived clear"); // R5
  AST_RELOAD_ON_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && armed_i) |=> cnt_q == $past(width_i)) else $error("reload wrong"); // R4
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fire_i && armed_i) |=> cnt_q == $past(cnt_q) - 1'b1) else $error("bad step"); // R3
  AST_START_FROM_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(fire_i)) else $error("pulse without trigger"); // R8
  AST_ZERO_WIDTH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && armed_i && width_i == '0) |=> !busy_o) else $error("zero width pulsed"); // R9

endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
  import oneshot_pkg::*;
#(
  parameter int unsigned WIDTH_W     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          RESET_TRIG  = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_n_i,
  input  logic               trig_p_i,
  input  logic               clear_ni,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               pulse_o,
  output logic               pulse_no
);

  logic [SAMPLE_W-1:0] raw, synced;
  trig_sample_t        cur;
  logic                fire, armed, busy;

  assign raw = {clear_ni, trig_p_i, trig_n_i};

  oneshot_sync #(
    .WIDTH  (SAMPLE_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SAMPLE_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign cur = trig_sample_t'(synced);

  oneshot_trigger #(
    .RESET_TRIG(RESET_TRIG)
  ) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (cur),
    .fire_o (fire),
    .armed_o(armed)
  );

  oneshot_timer #(
    .WIDTH_W(WIDTH_W)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .armed_i(armed),
    .width_i(width_i),
    .busy_o (busy)
  );

  // raw clear gates the output so the override needs no clock edge
  assign pulse_o  = busy & clear_ni;
  assign pulse_no = ~pulse_o;

  AST_OUT_FROM_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(fire) || $past(pulse_o)) else $error("output without cause"); // R3

endmodule

// File: tb/oneshot_pulse_tb_top.sv
module oneshot_pulse_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WW = 8;

  typedef struct packed {
    logic          a0;
    logic          b0;
    logic          a1;
    logic          b1;
    logic [WW-1:0] w;
    logic          exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'd4, 1'b1},  // R1 fall with p high
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd5, 1'b1},  // R2 rise with n low
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd4, 1'b0},  // R1 fall with p low
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd4, 1'b0},  // R2 rise with n high
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd4, 1'b0},  // R8 wrong edge on n
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd4, 1'b0},  // R8 wrong edge on p
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'd4, 1'b0},  // R8 static
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'd1, 1'b1},  // R3 width one
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'd0, 1'b0},  // R9 width zero
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd3, 1'b1}   // R1 both edges together
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a = 1'b1, b = 1'b1, clr_n = 1'b1;
  logic [WW-1:0] width = '0;
  logic          q, qn, q2, qn2;
  int            n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_pulse #(.WIDTH_W(WW), .RESET_TRIG(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_n_i(a), .trig_p_i(b), .clear_ni(clr_n),
    .width_i(width), .pulse_o(q), .pulse_no(qn));

  oneshot_pulse #(.WIDTH_W(WW), .RESET_TRIG(1'b0)) dut_nort_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_n_i(a), .trig_p_i(b), .clear_ni(clr_n),
    .width_i(width), .pulse_o(q2), .pulse_no(qn2));

  task automatic chk(input string req, input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    summary();
    $finish;
  end

  initial begin
    logic e;
    // reset state
    repeat (3) @(negedge clk);
    chk("R10 reset q", q, 1'b0);
    chk("R10 reset qn", qn, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      width = '0;
      a = VECS[i].a0;
      b = VECS[i].b0;
      repeat (6) @(negedge clk);
      width = VECS[i].w;
      a = VECS[i].a1;
      b = VECS[i].b1;
      for (int k = 1; k <= int'(VECS[i].w) + 4; k++) begin
        @(negedge clk);
        e = VECS[i].exp && (k >= 3) && (k <= int'(VECS[i].w) + 2);
        chk($sformatf("R3 vec%0d k%0d", i, k), q, e);
        chk("R10 complement", qn, ~e);
      end
    end

    // R4 retrigger with a shorter new width
    width = '0; a = 1'b0; b = 1'b0;
    repeat (6) @(negedge clk);
    width = 8'd6; b = 1'b1;                 // k0
    @(negedge clk); @(negedge clk);         // k2
    b = 1'b0;
    @(negedge clk); chk("R4 k3", q, 1'b1);
    @(negedge clk); chk("R4 k4", q, 1'b1);  // k4
    width = 8'd3; b = 1'b1;
    for (int k = 5; k <= 11; k++) begin
      @(negedge clk);
      chk($sformatf("R4 k%0d", k), q, (k <= 9));
    end

    // R5/R6 clear override and ignored triggers
    width = '0; a = 1'b1; b = 1'b1;
    repeat (6) @(negedge clk);
    width = 8'd8; a = 1'b0;                 // k0
    repeat (4) @(negedge clk);
    chk("R5 running before clear", q, 1'b1);
    clr_n = 1'b0;
    #1;
    chk("R5 immediate q", q, 1'b0);
    chk("R5 immediate qn", qn, 1'b1);
    @(negedge clk); a = 1'b1;               // k5
    @(negedge clk); a = 1'b0;               // k6 edge under clear
    @(negedge clk); @(negedge clk); a = 1'b1; // k8
    @(negedge clk); chk("R6 low under clear", q, 1'b0);
    @(negedge clk); clr_n = 1'b1;           // k10 release, n high
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chk("R5 no resume", q, 1'b0);
      chk("R6 no late fire", q2, 1'b0);
    end

    // R7 release of clear as trigger
    @(negedge clk);
    clr_n = 1'b0; a = 1'b0; b = 1'b1; width = 8'd4;
    repeat (4) @(negedge clk);
    clr_n = 1'b1;                           // k0
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk($sformatf("R7 enabled k%0d", k), q, (k >= 3 && k <= 6));
      chk($sformatf("R7 disabled k%0d", k), q2, 1'b0);
      chk("R10 complement", qn2, ~q2);
    end

    summary();
    $finish;
  end

endmodule